// File: doc/BRIEF.md
# Receive Holding Buffer with Error Reporting Modes

This block sits between a serial receive shift register and the CPU-facing registers of an asynchronous receiver. Each completed character arrives as a data byte with three per-character error flags (parity error, framing error, break). The buffer keeps up to three such entries, oldest first. The CPU sees the oldest entry at the head and removes it with a data-read pulse. A read of the status has no side effect, so status is never lost by looking at it.

The error flags are reported in one of two ways. In character mode the status shows the flags of the head entry only. In block mode the status shows the OR of the flags of every entry that has reached the head since the last clear-error command. When a character completes and all three slots are occupied, it waits in a single holding stage. If the next start bit comes before a slot frees up, the waiting character is discarded and a sticky overrun flag is raised. Overrun is not stored with any entry. An optional flow-control output asks the far end to stop sending when a start bit is seen while the buffer is full.

Top module: `rx_hold_fifo`

## Requirements
- R1: The buffer holds at most DEPTH (default 3) entries. `rx_rdy` is 1 while one or more entries are present, and `ffull` is 1 exactly when DEPTH entries are present.
- R2: `head_data` shows the data byte of the oldest entry, or 0 when the buffer is empty. A one-cycle `rd_pop` with the buffer not empty removes the head at the next clock edge. A `rd_pop` on an empty buffer has no effect.
- R3: Each entry stores its own parity, framing and break flags. With `blk_mode` = 0, `stat_perr`, `stat_ferr` and `stat_brk` equal the flags of the head entry, or 0 when the buffer is empty.
- R4: With `blk_mode` = 1, each status output is the OR of that flag over every entry that has become the head since the last `clr_err` pulse. The OR is kept whichever mode is selected. An entry becomes the head when it is written into an empty buffer, or when the entry in front of it is popped.
- R5: A character that completes while the buffer is full waits in the holding stage. It enters the buffer one clock cycle after the pop that frees a slot. Characters keep their arrival order.
- R6: A `start_det` pulse that arrives while a character is waiting and the buffer is still full discards the waiting character and leaves the buffer contents unchanged. From the next cycle `overrun` reads 1.
- R7: A `clr_err` pulse clears `overrun` and the block-mode OR at the next edge. A head change in the same cycle is ORed in after the clear. A discard in the same cycle still sets `overrun`.
- R8: With `rts_en` = 1, `rts_n` goes to 1 after a `start_det` that occurs while the buffer is full. It returns to 0 on the edge after a cycle in which the buffer is not full. With `rts_en` = 0, `rts_n` is 0 from the next edge.
- R9: After reset the buffer is empty, nothing is waiting, and every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | One-cycle pulse: a character has completed in the shift register |
| char_data | input | DW | Data byte of the completed character |
| char_perr | input | 1 | Parity error of the completed character |
| char_ferr | input | 1 | Framing error of the completed character |
| char_brk | input | 1 | Break flag of the completed character |
| start_det | input | 1 | One-cycle pulse: a valid start bit was detected |
| rd_pop | input | 1 | One-cycle pulse: CPU data read, pops the head |
| blk_mode | input | 1 | 1 selects accumulated (block) error reporting |
| clr_err | input | 1 | One-cycle pulse: clear overrun and accumulated error flags |
| rts_en | input | 1 | Enables receiver-driven flow control on `rts_n` |
| head_data | output | DW | Data of the head entry |
| rx_rdy | output | 1 | At least one entry is present |
| ffull | output | 1 | All slots are occupied |
| overrun | output | 1 | Sticky overrun flag |
| stat_perr | output | 1 | Reported parity error |
| stat_ferr | output | 1 | Reported framing error |
| stat_brk | output | 1 | Reported break |
| rts_n | output | 1 | Flow control: 1 asks the sender to stop |

## Verification
The bench builds the block with DEPTH = 3 and DW = 8. With three slots the buffer fills after a few writes, so the full-buffer corner cases come up often: a character waiting in the holding stage, the move from that stage one cycle after a pop, a discard on a start bit, and the flow-control output rising and falling. Directed sequences cover each of these cases and the block-mode OR across a clear. A long random run then toggles the mode, the clear and the flow-control enable while writes, reads and start bits overlap in the same cycle. A queue-based reference model checks every output on every cycle.

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_valid,
  input  logic [DW-1:0] char_data,
  input  logic          char_perr,
  input  logic          char_ferr,
  input  logic          char_brk,
  input  logic          start_det,
  input  logic          rd_pop,
  input  logic          blk_mode,
  input  logic          clr_err,
  input  logic          rts_en,
  output logic [DW-1:0] head_data,
  output logic          rx_rdy,
  output logic          ffull,
  output logic          overrun,
  output logic          stat_perr,
  output logic          stat_ferr,
  output logic          stat_brk,
  output logic          rts_n
);
  localparam int EW = DW + 3;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [EW-1:0] hold;
  logic          hold_v;
  logic [2:0]    acc;
  logic          ovr_q, rts_q;

  wire [EW-1:0] in_ent  = {char_brk, char_ferr, char_perr, char_data};
  wire          full    = (cnt == CW'(DEPTH));
  wire          empty   = (cnt == '0);
  wire          pop     = rd_pop && !empty;
  wire          wr      = (hold_v || char_valid) && !full;
  wire [EW-1:0] wr_ent  = hold_v ? hold : in_ent;
  wire [CW-1:0] wr_idx  = pop ? cnt - 1'b1 : cnt;
  wire [CW-1:0] nxt_cnt = cnt + CW'(wr) - CW'(pop);
  wire          lost    = start_det && hold_v && full;
  wire          head_ev = (nxt_cnt != '0) && (empty || pop);
  wire [2:0]    nh_bits = (pop && cnt >= CW'(2)) ? mem[1][EW-1:DW] : wr_ent[EW-1:DW];
  wire [2:0]    hd_bits = empty ? 3'b000 : mem[0][EW-1:DW];
  wire [2:0]    stat    = blk_mode ? acc : hd_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cnt <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && i < DEPTH - 1) mem[i] <= mem[i+1];
        if (wr && CW'(i) == wr_idx) mem[i] <= wr_ent;
      end
      cnt <= nxt_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      hold_v <= 1'b0;
    end else begin
      if (lost || (wr && hold_v)) hold_v <= 1'b0;
      if (char_valid && (hold_v || full)) begin
        hold   <= in_ent;
        hold_v <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      ovr_q <= 1'b0;
      rts_q <= 1'b0;
    end else begin
      if (head_ev)      acc <= (clr_err ? 3'b000 : acc) | nh_bits;
      else if (clr_err) acc <= 3'b000;
      if (lost)         ovr_q <= 1'b1;
      else if (clr_err) ovr_q <= 1'b0;
      if (!rts_en)                rts_q <= 1'b0;
      else if (start_det && full) rts_q <= 1'b1;
      else if (!full)             rts_q <= 1'b0;
    end
  end

  assign head_data = empty ? '0 : mem[0][DW-1:0];
  assign rx_rdy    = !empty;
  assign ffull     = full;
  assign overrun   = ovr_q;
  assign stat_perr = stat[0];
  assign stat_ferr = stat[1];
  assign stat_brk  = stat[2];
  assign rts_n     = rts_q;
endmodule

module rx_hold_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic start_det,
  input logic rd_pop,
  input logic blk_mode,
  input logic clr_err,
  input logic rts_en,
  input logic rx_rdy,
  input logic ffull,
  input logic overrun,
  input logic stat_perr,
  input logic stat_ferr,
  input logic stat_brk,
  input logic rts_n
);
  // R1
  full_means_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ffull |-> rx_rdy);
  // R5
  full_holds_without_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ffull && !rd_pop) |=> ffull);
  // R3
  empty_char_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_rdy && !blk_mode) |-> !(stat_perr || stat_ferr || stat_brk));
  // R6
  overrun_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(start_det));
  // R7
  clear_drops_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !start_det) |=> !overrun);
  // R8
  rts_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && start_det && ffull) |=> rts_n);
  // R8
  rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_en |=> !rts_n);
endmodule

bind rx_hold_fifo rx_hold_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .rd_pop(rd_pop),
  .blk_mode(blk_mode), .clr_err(clr_err), .rts_en(rts_en), .rx_rdy(rx_rdy),
  .ffull(ffull), .overrun(overrun), .stat_perr(stat_perr),
  .stat_ferr(stat_ferr), .stat_brk(stat_brk), .rts_n(rts_n)
);

// File: tb/rx_hold_fifo_bench.sv
`timescale 1ns/1ps
module rx_hold_fifo_bench;
  localparam int DEPTH = 3;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic char_valid = 0, char_perr = 0, char_ferr = 0, char_brk = 0;
  logic [DW-1:0] char_data = '0;
  logic start_det = 0, rd_pop = 0, blk_mode = 0, clr_err = 0, rts_en = 0;
  logic [DW-1:0] head_data;
  logic rx_rdy, ffull, overrun, stat_perr, stat_ferr, stat_brk, rts_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_hold_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_hold_fifo (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
    .start_det(start_det), .rd_pop(rd_pop), .blk_mode(blk_mode),
    .clr_err(clr_err), .rts_en(rts_en), .head_data(head_data),
    .rx_rdy(rx_rdy), .ffull(ffull), .overrun(overrun), .stat_perr(stat_perr),
    .stat_ferr(stat_ferr), .stat_brk(stat_brk), .rts_n(rts_n)
  );

  // reference model: entry = {brk, ferr, perr, data}
  logic [DW+2:0] q[$];
  logic [DW+2:0] m_hold;
  bit m_hold_v, m_ovr, m_rts;
  logic [2:0] m_acc;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_hold_v = 0; m_ovr = 0; m_rts = 0; m_acc = 0;
    end else begin
      int old_n;
      bit was_full, p, mv, from_hold, lose;
      logic [DW+2:0] inc, ent;
      old_n = q.size();
      was_full = (old_n == DEPTH);
      inc = {char_brk, char_ferr, char_perr, char_data};
      p = rd_pop && old_n > 0;
      mv = (m_hold_v || char_valid) && !was_full;
      from_hold = m_hold_v;
      ent = m_hold_v ? m_hold : inc;
      lose = start_det && m_hold_v && was_full;
      if (p) void'(q.pop_front());
      if (mv) q.push_back(ent);
      if (q.size() > 0 && (old_n == 0 || p)) m_acc = (clr_err ? 3'b000 : m_acc) | q[0][DW+2:DW];
      else if (clr_err) m_acc = 3'b000;
      if (lose || (mv && from_hold)) m_hold_v = 0;
      if (char_valid && (from_hold || was_full)) begin m_hold = inc; m_hold_v = 1; end
      if (lose) m_ovr = 1; else if (clr_err) m_ovr = 0;
      if (!rts_en) m_rts = 0;
      else if (start_det && was_full) m_rts = 1;
      else if (!was_full) m_rts = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [2:0] hb, st;
    hb = (q.size() > 0) ? q[0][DW+2:DW] : 3'b000;
    st = blk_mode ? m_acc : hb;
    chk("R1 rx_rdy", rx_rdy, q.size() > 0);
    chk("R1 ffull", ffull, q.size() == DEPTH);
    chk("R2 head_data", head_data, (q.size() > 0) ? q[0][DW-1:0] : 0);
    chk(blk_mode ? "R4 status" : "R3 status", {stat_brk, stat_ferr, stat_perr}, st);
    chk("R6 overrun", overrun, m_ovr);
    chk("R8 rts_n", rts_n, m_rts);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic idle_inputs();
    char_valid = 0; start_det = 0; rd_pop = 0; clr_err = 0;
    char_perr = 0; char_ferr = 0; char_brk = 0;
  endtask

  task automatic push(logic [DW-1:0] d, logic [2:0] e);
    char_valid = 1; char_data = d; {char_brk, char_ferr, char_perr} = e;
    tick(); idle_inputs();
  endtask

  task automatic pop1();
    rd_pop = 1; tick(); idle_inputs();
  endtask

  task automatic pulse_start();
    start_det = 1; tick(); idle_inputs();
  endtask

  task automatic pulse_clr();
    clr_err = 1; tick(); idle_inputs();
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) pop1();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 rx_rdy", rx_rdy, 0);
    chk("R9 head_data", head_data, 0);
    chk("R9 flags", {ffull, overrun, stat_perr, stat_ferr, stat_brk, rts_n}, 0);
    rst_n = 1;
    tick();

    // R2/R3: character mode, mixed errors, read on empty
    pop1();
    chk("R2 empty pop", rx_rdy, 0);
    push(8'hA1, 3'b001); push(8'hB2, 3'b010); push(8'hC3, 3'b100);
    chk("R3 head flags", {stat_brk, stat_ferr, stat_perr}, 3'b001);
    pop1();
    chk("R3 second head", {stat_brk, stat_ferr, stat_perr}, 3'b010);
    chk("R2 second data", head_data, 8'hB2);
    drain();

    // R5: waiting character enters the cycle after a pop
    push(8'h10, 0); push(8'h11, 0); push(8'h12, 0); push(8'h13, 0);
    pop1();
    chk("R5 slot free", ffull, 0);
    tick();
    chk("R5 refilled", ffull, 1);
    pop1(); pop1();
    chk("R5 order", head_data, 8'h13);
    drain();

    // R6/R7: discard on start bit, then clear
    push(8'h20, 0); push(8'h21, 0); push(8'h22, 0); push(8'h23, 0);
    pulse_start();
    chk("R6 overrun set", overrun, 1);
    chk("R6 contents kept", head_data, 8'h20);
    pop1(); tick(); pop1(); pop1();
    chk("R6 waiting lost", rx_rdy, 0);
    pulse_clr();
    chk("R7 overrun cleared", overrun, 0);

    // R4/R7: block mode accumulation
    blk_mode = 1; pulse_clr();
    push(8'h30, 3'b001); push(8'h31, 3'b010);
    chk("R4 first head", {stat_brk, stat_ferr, stat_perr}, 3'b001);
    pop1();
    chk("R4 ored", {stat_brk, stat_ferr, stat_perr}, 3'b011);
    pulse_clr();
    chk("R7 acc cleared", {stat_brk, stat_ferr, stat_perr}, 3'b000);
    drain();
    blk_mode = 0;

    // R8: flow control
    rts_en = 1; tick();
    push(8'h40, 0); push(8'h41, 0); push(8'h42, 0);
    pulse_start();
    chk("R8 raised", rts_n, 1);
    pop1(); tick();
    chk("R8 lowered", rts_n, 0);
    drain();

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      char_valid = ($urandom_range(0, 99) < 35);
      char_data  = DW'($urandom);
      {char_brk, char_ferr, char_perr} = 3'($urandom);
      start_det  = ($urandom_range(0, 99) < 25);
      rd_pop     = ($urandom_range(0, 99) < 25);
      clr_err    = ($urandom_range(0, 99) < 5);
      if ($urandom_range(0, 99) < 5) blk_mode = ~blk_mode;
      if ($urandom_range(0, 99) < 3) rts_en = ~rts_en;
      tick();
    end
    idle_inputs();
    tick();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule